// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a small 32-bit processor and works out the address of the instruction that follows the current one. Each cycle it receives a decoded flow class (plain sequential step, branch when operands match, branch when operands differ, or jump through a register), the two register operands read for the instruction and its 16-bit immediate. From these it forms the next address and a flag telling the fetch side that control flow was redirected.

Conditional targets are relative: the immediate is treated as a signed count of 4-byte words and added to the address of the following instruction, so both forward and backward targets are reachable. A register jump takes the full 32-bit value of the first operand. The next address is presented combinationally and is loaded into the program counter on a clock edge only while the advance enable is high. The enable is a plain control pin, not a handshake: there is no back-pressure, and a stall is simply the enable held low.

Top module: `npc_unit`

## Requirements
- R1: After reset, and whenever reset is reasserted, the program counter `pc` reads 0x00000000.
- R2: With flow class 0 (sequential), `pc_next` equals `pc` + 4 and `taken` is low, whatever the operands and immediate are.
- R3: With flow class 1 (branch on equal) and `opa` equal to `opb`, `taken` is high and `pc_next` equals `pc` + 4 + 4 × (signed value of `imm`).
- R4: With flow class 2 (branch on not equal) and `opa` different from `opb`, `taken` is high and `pc_next` equals `pc` + 4 + 4 × (signed value of `imm`).
- R5: A conditional branch whose condition fails gives `pc_next` = `pc` + 4 with `taken` low.
- R6: The immediate is sign-extended before being scaled by 4: values 0x8000 to 0xFFFF move the target backwards, down to 32768 words before `pc` + 4.
- R7: With flow class 3 (register jump), `pc_next` equals the full 32-bit `opa` and `taken` is high.
- R8: On a rising clock edge with `adv_en` high, `pc` takes the value `pc_next` had before the edge; with `adv_en` low, `pc` is unchanged.
- R9: All address arithmetic wraps modulo 2^32 (0xFFFFFFFC steps to 0x00000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | 1 | Load `pc_next` into `pc` on this edge |
| flow | input | 2 | Flow class: 0 sequential, 1 branch on equal, 2 branch on not equal, 3 register jump |
| opa | input | 32 | First register operand; jump target for class 3 |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Instruction immediate, signed word offset |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address of the next instruction |
| taken | output | 1 | High when control flow leaves the sequential path |

## Verification
The hardest cases to reach are branches taken from an arbitrary program counter, since `pc` can only be steered through the block's own flow: after reset it starts at zero and only ever steps by 4. The bench therefore first issues a register jump with the enable high to place `pc` at the address each vector needs (including 0xFFFFFFFC for the wrap case and a low address for a backward branch that wraps below zero), then applies the vector with the enable low, checks the combinational outputs and finally advances to check the registered value.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BEQ  = 2'd1,
    FLOW_BNE  = 2'd2,
    FLOW_JREG = 2'd3
  } flow_e;

endpackage

// File: rtl/npc_disp.sv
// Forms the signed, word-scaled displacement from the immediate field.
module npc_disp #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int SCALE_SH = 2
) (
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  disp
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign ext = imm[XLEN-1:0];
    end
  endgenerate

  assign disp = ext << SCALE_SH;
endmodule

// File: rtl/npc_cond.sv
// Decides whether the current flow class leaves the sequential path.
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e           flow,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            take_rel,
  output logic            take_abs
);
  logic same;
  assign same = (opa == opb);

  always_comb begin
    take_rel = 1'b0;
    take_abs = 1'b0;
    unique case (flow)
      FLOW_SEQ:  ;
      FLOW_BEQ:  take_rel = same;
      FLOW_BNE:  take_rel = ~same;
      FLOW_JREG: take_abs = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/npc_sel.sv
// Picks among the sequential, relative and absolute targets.
module npc_sel #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] rel_addr,
  input  logic [XLEN-1:0] abs_addr,
  input  logic            take_rel,
  input  logic            take_abs,
  output logic [XLEN-1:0] nxt,
  output logic            redirect
);
  always_comb begin
    if (take_abs)      nxt = abs_addr;
    else if (take_rel) nxt = rel_addr;
    else               nxt = seq_addr;
  end
  assign redirect = take_abs | take_rel;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          IMM_W       = 16,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_ADDR  = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [1:0]       flow,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  pc_next,
  output logic             taken
);
  localparam int              SCALE_SH = $clog2(INSTR_BYTES);
  localparam logic [XLEN-1:0] STEP     = XLEN'(INSTR_BYTES);
  localparam logic [XLEN-1:0] RST_PC   = XLEN'(RESET_ADDR);

  flow_e           flow_q;
  logic [XLEN-1:0] pc_r;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] rel_addr;
  logic            take_rel;
  logic            take_abs;
  logic [XLEN-1:0] nxt;
  logic            redirect;

  assign flow_q   = flow_e'(flow);
  assign seq_addr = pc_r + STEP;
  assign rel_addr = seq_addr + disp;

  npc_disp #(.XLEN(XLEN), .IMM_W(IMM_W), .SCALE_SH(SCALE_SH)) u_disp (
    .imm  (imm),
    .disp (disp)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .flow     (flow_q),
    .opa      (opa),
    .opb      (opb),
    .take_rel (take_rel),
    .take_abs (take_abs)
  );

  npc_sel #(.XLEN(XLEN)) u_sel (
    .seq_addr (seq_addr),
    .rel_addr (rel_addr),
    .abs_addr (opa),
    .take_rel (take_rel),
    .take_abs (take_abs),
    .nxt      (nxt),
    .redirect (redirect)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_r <= RST_PC;
    else if (adv_en) pc_r <= nxt;
  end

  assign pc      = pc_r;
  assign pc_next = nxt;
  assign taken   = redirect;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv_en,
  input logic [1:0]       flow,
  input logic [XLEN-1:0]  opa,
  input logic [XLEN-1:0]  opb,
  input logic [IMM_W-1:0] imm,
  input logic [XLEN-1:0]  pc,
  input logic [XLEN-1:0]  pc_next,
  input logic             taken
);
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == 2'd0) |-> (pc_next == pc + FOUR) && !taken);

  p_beq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == 2'd1) |-> (taken == (opa == opb)));

  p_bne_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == 2'd2) |-> (taken == (opa != opb)));

  p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (pc_next == pc + FOUR));

  p_jreg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flow == 2'd3) |-> (pc_next == opa) && taken);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> (pc == $past(pc_next)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(pc));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .adv_en  (adv_en),
  .flow    (flow),
  .opa     (opa),
  .opb     (opb),
  .imm     (imm),
  .pc      (pc),
  .pc_next (pc_next),
  .taken   (taken)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_en = 1'b0;
  logic [1:0]  flow = 2'd0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [15:0] imm = '0;
  logic [31:0] pc;
  logic [31:0] pc_next;
  logic        taken;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .flow(flow),
    .opa(opa), .opb(opb), .imm(imm),
    .pc(pc), .pc_next(pc_next), .taken(taken)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [1:0]  cls;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] off;
    logic [31:0] exp_nxt;
    logic        exp_tk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    // R2 sequential, immediate ignored
    '{32'h0000_1000, 2'd0, 32'h5, 32'h5, 16'h1234, 32'h0000_1004, 1'b0, 8'd2},
    // R3 equal operands, forward
    '{32'h0000_1000, 2'd1, 32'h5, 32'h5, 16'h0010, 32'h0000_1044, 1'b1, 8'd3},
    // R5 equal test fails
    '{32'h0000_1000, 2'd1, 32'h5, 32'h6, 16'h0010, 32'h0000_1004, 1'b0, 8'd5},
    // R4 differ, offset -1 word
    '{32'h0000_2000, 2'd2, 32'h1, 32'h2, 16'hFFFF, 32'h0000_2000, 1'b1, 8'd4},
    // R5 not-equal test fails
    '{32'h0000_2000, 2'd2, 32'h7, 32'h7, 16'hFFFE, 32'h0000_2004, 1'b0, 8'd5},
    // R6 most negative offset
    '{32'h0040_0000, 2'd1, 32'h0, 32'h0, 16'h8000, 32'h003E_0004, 1'b1, 8'd6},
    // R4 differ only in bit 31, largest forward offset
    '{32'h0000_0100, 2'd2, 32'h0, 32'h8000_0000, 16'h7FFF, 32'h0002_0100, 1'b1, 8'd4},
    // R7 register jump
    '{32'h0000_3000, 2'd3, 32'hDEAD_BEE0, 32'h0, 16'h0004, 32'hDEAD_BEE0, 1'b1, 8'd7},
    // R9 sequential wrap
    '{32'hFFFF_FFFC, 2'd0, 32'h0, 32'h1, 16'h0000, 32'h0000_0000, 1'b0, 8'd9},
    // R9 backward branch below zero wraps
    '{32'h0000_0010, 2'd1, 32'hFF, 32'hFF, 16'hFFF0, 32'hFFFF_FFD4, 1'b1, 8'd9}
  };

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // place pc at a chosen address with a register jump
  task automatic steer(input logic [31:0] addr);
    @(negedge clk);
    flow = 2'd3; opa = addr; adv_en = 1'b1;
    @(negedge clk);
    adv_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk32("R1 reset pc", pc, 32'h0);
    chk32("R2 reset next", pc_next, 32'h4);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      steer(TBL[i].start);
      chk32("R7 steer pc", pc, TBL[i].start);
      flow = TBL[i].cls; opa = TBL[i].a; opb = TBL[i].b; imm = TBL[i].off;
      #1;
      chk32($sformatf("R%0d vec%0d next", TBL[i].req, i), pc_next, TBL[i].exp_nxt);
      chk1($sformatf("R%0d vec%0d taken", TBL[i].req, i), taken, TBL[i].exp_tk);
      adv_en = 1'b1;
      @(negedge clk);
      adv_en = 1'b0;
      #1;
      chk32($sformatf("R8 vec%0d loaded", i), pc, TBL[i].exp_nxt);
    end

    // R8 enable low holds pc
    steer(32'h0000_5000);
    flow = 2'd0;
    repeat (3) @(negedge clk);
    #1;
    chk32("R8 hold", pc, 32'h0000_5000);
    // R8 repeated stepping
    adv_en = 1'b1;
    repeat (3) @(negedge clk);
    adv_en = 1'b0;
    #1;
    chk32("R8 step x3", pc, 32'h0000_500C);

    // R1 reset reasserted mid run
    rst_n = 1'b0;
    #1;
    chk32("R1 reset again", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk32("R1 after release", pc, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule